// File: doc/BRIEF.md
# Counting Stream Source

This block is a stream master that emits packets of incrementing words, used to feed a stream-to-memory engine during bring-up. Software places a packet length on the `limit` input and pulses `start`. The block then offers the values 0, 1, 2 and so on. It moves to the next value only when the receiver accepts the current beat. It flags the final value with `tlast`, then goes quiet until the next start.

The receiver may withdraw `tready` at any point in a packet. While a beat waits, the offered word, its valid flag and its last flag stay frozen, so the receiver sees every value exactly once. The length is captured on the start pulse. Later changes on `limit` do not disturb the packet in flight. A start pulse that arrives while a packet is running is dropped.

Top module: `count_stream_src`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `tvalid` and `tlast` at 0 and `tdata` at 0 after that edge.
- R2: When idle, a `start` pulse with `limit` = N > 0 raises `tvalid` in the next cycle, and the first beat offered carries `tdata` = 0.
- R3: Each accepted beat (`tvalid` and `tready` both high at an edge) that is not the last one makes the next offered `tdata` exactly one greater. Without acceptance, `tdata` does not advance.
- R4: While `tvalid` is high and `tready` is low, `tvalid` stays high and `tdata` and `tlast` keep their values in the following cycle.
- R5: `tlast` is high only on the beat carrying N-1, and a packet contains exactly N beats.
- R6: In the cycle after the last beat is accepted, `tvalid` is 0. It stays 0 until a new start is accepted.
- R7: A `start` pulse while `tvalid` is high is ignored, including in the cycle in which the last beat is accepted. The sequence of values offered is unchanged, and the block goes idle after the last beat.
- R8: A `start` pulse with `limit` = 0 produces no beats: `tvalid` stays 0.
- R9: `limit` is sampled only in the cycle of an accepted start. Changing it during a packet does not change the packet's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a packet |
| limit | input | LIM_W (16) | Number of beats in the next packet |
| tready | input | 1 | Receiver accepts the offered beat |
| tdata | output | DATA_W (32) | Offered count value |
| tvalid | output | 1 | A beat is offered |
| tlast | output | 1 | Offered beat is the packet's final one |

## Verification
Two functions can meet in one cycle: acceptance of the final beat, and a fresh `start` pulse. To provoke this, the bench raises `start` at the same edge where `tready` takes the beat that carries `tlast`. The result is judged by `tvalid` being 0 in the following cycle and staying 0, which shows the start was discarded rather than opening a new packet. Mid-packet starts and length changes under irregular ready patterns are judged by the exact value sequence offered.

// File: rtl/csrc_pkg.sv
package csrc_pkg;
  typedef struct packed {
    logic load;     // capture limit, restart count at 0
    logic advance;  // non-final beat accepted
    logic finish;   // final beat accepted
  } strobe_t;
endpackage

// File: rtl/csrc_ctrl.sv
module csrc_ctrl
  import csrc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    limitNonZero,
  input  logic    tready,
  input  logic    isLast,
  output strobe_t strobes,
  output logic    busy
);
  always_comb begin
    strobes.load    = !busy && start && limitNonZero;
    strobes.advance = busy && tready && !isLast;
    strobes.finish  = busy && tready && isLast;
  end

  always_ff @(posedge clk) begin
    if (rst)                busy <= 1'b0;
    else if (strobes.load)  busy <= 1'b1;
    else if (strobes.finish) busy <= 1'b0;
  end
endmodule

// File: rtl/csrc_datapath.sv
module csrc_datapath
  import csrc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [LIM_W-1:0]  limit,
  output logic [DATA_W-1:0] count,
  output logic              isLast
);
  logic [LIM_W-1:0]  limReg;
  logic [DATA_W-1:0] limExt;
  logic [DATA_W-1:0] countPlus2;

  assign limExt     = DATA_W'(limReg);
  assign countPlus2 = count + DATA_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      limReg <= '0;
      isLast <= 1'b0;
    end else if (strobes.load) begin
      count  <= '0;
      limReg <= limit;
      isLast <= (limit == LIM_W'(1));
    end else if (strobes.advance) begin
      count  <= count + DATA_W'(1);
      isLast <= (countPlus2 == limExt);
    end else if (strobes.finish) begin
      isLast <= 1'b0;
    end
  end
endmodule

// File: rtl/count_stream_src.sv
module count_stream_src
  import csrc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LIM_W-1:0]  limit,
  input  logic              tready,
  output logic [DATA_W-1:0] tdata,
  output logic              tvalid,
  output logic              tlast
);
  strobe_t strobes;
  logic    busy;
  logic    isLast;
  logic    limitNonZero;

  assign limitNonZero = (limit != '0);

  csrc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .limitNonZero(limitNonZero),
    .tready(tready), .isLast(isLast), .strobes(strobes), .busy(busy)
  );

  csrc_datapath #(.DATA_W(DATA_W), .LIM_W(LIM_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .limit(limit),
    .count(tdata), .isLast(isLast)
  );

  assign tvalid = busy;
  assign tlast  = isLast;
endmodule

// File: rtl/count_stream_src_chk.sv
module count_stream_src_chk #(
  parameter int DATA_W = 32,
  parameter int LIM_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [LIM_W-1:0]  limit,
  input logic              tready,
  input logic [DATA_W-1:0] tdata,
  input logic              tvalid,
  input logic              tlast
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!tvalid && !tlast && tdata == '0));

  assert_first_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tvalid) |-> tdata == '0);

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    (tvalid && tready && !tlast) |=> (tvalid && tdata == $past(tdata) + DATA_W'(1)));

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast)));

  assert_last_has_valid_R5: assert property (@(posedge clk) disable iff (rst)
    tlast |-> tvalid);

  assert_idle_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    (tvalid && tready && tlast) |=> !tvalid);

  assert_start_on_last_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (tvalid && tready && tlast && start) |=> !tvalid);

  assert_zero_limit_R8: assert property (@(posedge clk) disable iff (rst)
    (!tvalid && start && limit == '0) |=> !tvalid);
endmodule

bind count_stream_src count_stream_src_chk #(.DATA_W(DATA_W), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .limit(limit), .tready(tready),
  .tdata(tdata), .tvalid(tvalid), .tlast(tlast)
);

// File: tb/count_stream_src_test.sv
module count_stream_src_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int LIM_W  = 16;
  localparam int NVEC   = 7;
  localparam int VEC_LIM [NVEC] = '{20, 32, 1, 5, 2, 9, 12};
  localparam logic [7:0] VEC_PAT [NVEC] =
    '{8'hFF, 8'b10110110, 8'hFF, 8'b00010001, 8'b00000001, 8'hFF, 8'b01101011};
  localparam bit VEC_POKE [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LIM_W-1:0] limitIn = '0;
  logic tready = 1'b0;
  logic [DATA_W-1:0] tdata;
  logic tvalid, tlast;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  count_stream_src #(.DATA_W(DATA_W), .LIM_W(LIM_W)) uut (
    .clk(clk), .rst(rst), .start(start), .limit(limitIn), .tready(tready),
    .tdata(tdata), .tvalid(tvalid), .tlast(tlast)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Runs one packet; limit changed right after start (R9), optional start pokes (R7).
  task automatic runPacket(input int lim, input logic [7:0] pat, input bit poke);
    int expv = 0;
    int k = 0;
    bit took;
    @(negedge clk);
    start = 1'b1; limitIn = LIM_W'(lim);
    @(negedge clk);
    start = 1'b0; limitIn = LIM_W'(lim + 5);
    while (expv < lim && k < 2000) begin
      tready = pat[k % 8];
      start  = poke && ((k % 3 == 1) || (expv == lim - 1 && pat[k % 8]));
      check(tvalid == 1'b1, "R2 tvalid", int'(tvalid), 1);
      check(tdata == DATA_W'(expv), "R3 tdata", int'(tdata), expv);
      check(tlast == (expv == lim - 1), "R5 tlast", int'(tlast), int'(expv == lim - 1));
      took = tready;
      @(negedge clk);
      k++;
      if (took) expv++;
    end
    start = 1'b0; tready = 1'b0;
    check(k < 2000, "R5 packet ends", k, lim);
    check(tvalid == 1'b0, "R6 idle after last", int'(tvalid), 0);
    tready = 1'b1;
    repeat (3) @(negedge clk);
    check(tvalid == 1'b0, "R6 stays idle", int'(tvalid), 0);
    tready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(tvalid == 1'b0 && tlast == 1'b0, "R1 reset flags", int'({tvalid, tlast}), 0);
    check(tdata == '0, "R1 reset data", int'(tdata), 0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) runPacket(VEC_LIM[v], VEC_PAT[v], VEC_POKE[v]);

    // R8: zero length gives no beats
    @(negedge clk); start = 1'b1; limitIn = '0; tready = 1'b1;
    @(negedge clk); start = 1'b0;
    check(tvalid == 1'b0, "R8 zero limit", int'(tvalid), 0);
    repeat (3) @(negedge clk);
    check(tvalid == 1'b0, "R8 zero limit later", int'(tvalid), 0);
    tready = 1'b0;

    // R4: long stall holds the beat
    @(negedge clk); start = 1'b1; limitIn = 16'd4;
    @(negedge clk); start = 1'b0; tready = 1'b1;
    @(negedge clk); tready = 1'b0;
    repeat (5) @(negedge clk);
    check(tvalid && tdata == 32'd1 && !tlast, "R4 stall hold", int'(tdata), 1);

    // R1: reset in mid-packet
    rst = 1'b1;
    @(negedge clk);
    check(!tvalid && !tlast && tdata == '0, "R1 mid-packet reset", int'(tdata), 0);
    rst = 1'b0;
    runPacket(3, 8'hFF, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule